// File: doc/BRIEF.md
# Link and Traffic LED Event Controller

This block drives a small bank of LED outputs from the live state of an Ethernet port: link up, negotiated speed, duplex, collision and transmit/receive activity strobes. Each LED is given a 5-bit event code that decides what lights it. The code can pick a single speed, a group of speeds, duplex or collision, activity blinking, a mix of a steady-on condition with an activity blink, or a forced state.

A simple register port holds the configuration. There is one event register per LED, placed on a fixed stride. One shared register sets the blink period and another holds one polarity bit per LED. Blinking runs from a common period counter. The period is the blink rate plus one, times a fixed prescale, in clock cycles. Activity seen in one period keeps the LED blinking through the next period. An LED returns to its steady state once a whole period passes with no activity.

Top module: `led_event_ctrl`

## Requirements
- R1: While reset is held and after it is released, every LED output is low, read data is zero, every event code is 0x15 (off), all polarity bits are clear and the blink rate is 0x0F.
- R2: LED i has its event register at address 0x40 + 0x10*i, with the code in bits 15:11. The polarity register is at 0x00, with bit 8+i for LED i in bits 12:8. The blink-rate register is at 0x08, with the rate in bits 7:0. A read returns the stored field in place, with every other bit zero, in the cycle after rd_en. When no read was issued, read data is zero. A write to any other address changes nothing.
- R3: Speed is encoded as 0=10M, 1=100M, 2=1G, 3=2.5G, 4=5G, 5=10G. Codes 0x0 to 0x5 light the LED only while link is up at the speed whose encoding equals the code. An LED output follows a change of its inputs one clock later.
- R4: Code 0x6 lights the LED for a link at 100M or 1G. Code 0x7 lights it for a link at 2.5G, 5G or 10G.
- R5: Code 0x8 lights the LED for a full-duplex link. Code 0x9 lights it while collision is high. Code 0xD lights it for any link.
- R6: Codes 0xA, 0xB and 0xC blink the LED on transmit, receive or either strobe. While activity continues, the output toggles once every (rate+1)*PRESCALE cycles. Once strobes stop, the LED settles off within three periods and then stays steady.
- R7: Codes 0xE, 0xF, 0x10, 0x11 and 0x13 light the LED steadily on their base condition. The base conditions are any link, any link, the 100M/1G group, the 2.5G-10G group, and a full-duplex link. The LED blinks only while the matching activity is present: any strobe, receive only, any strobe, any strobe, and collision.
- R8: Code 0x12 lights the LED steadily on a 2.5G-10G link and blinks it continuously on a 100M/1G link, with no activity needed.
- R9: Code 0x14 forces the LED on and code 0x15 forces it off. Codes 0x16 to 0x1F drive it off.
- R10: A set polarity bit makes that LED's output active-low, inverting the output level for every code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid the cycle after rd_en |
| link_up | input | 1 | Link is up |
| speed | input | 3 | Link speed encoding |
| full_dup | input | 1 | Full duplex |
| collision | input | 1 | Collision level |
| tx_pulse | input | 1 | Transmit activity strobe |
| rx_pulse | input | 1 | Receive activity strobe |
| led_o | output | 5 | LED drive outputs |

## Verification
Steady LED results are due one clock after a status change, or two clocks after a configuration write: one edge stores the code and the next registers the output. The driver therefore waits two rising edges before it queues an expectation. The monitor then compares that expectation on the following falling edge. Read data is queued for the first falling edge after the edge that captured rd_en. Blinking is checked by timing the gaps between output toggles against the exact period. Settling is checked only after three idle periods, which is the latest point an activity flag can still be held.

// File: rtl/led_evt_pkg.sv
package led_evt_pkg;

  localparam int EVT_W = 5;

  typedef enum logic [4:0] {
    EV_10M       = 5'h00,
    EV_100M      = 5'h01,
    EV_1G        = 5'h02,
    EV_2G5       = 5'h03,
    EV_5G        = 5'h04,
    EV_10G       = 5'h05,
    EV_LOWGRP    = 5'h06,
    EV_HIGHGRP   = 5'h07,
    EV_FDX       = 5'h08,
    EV_COL       = 5'h09,
    EV_TX_BLINK  = 5'h0A,
    EV_RX_BLINK  = 5'h0B,
    EV_ACT_BLINK = 5'h0C,
    EV_LINK      = 5'h0D,
    EV_LINK_ACT  = 5'h0E,
    EV_LINK_RX   = 5'h0F,
    EV_LOW_ACT   = 5'h10,
    EV_HIGH_ACT  = 5'h11,
    EV_HIGH_LOWB = 5'h12,
    EV_FDX_COLB  = 5'h13,
    EV_FORCE_ON  = 5'h14,
    EV_FORCE_OFF = 5'h15
  } evt_e;

  typedef struct packed {
    logic       link;
    logic [2:0] spd;
    logic       fdx;
    logic       col;
    logic       tx_act;
    logic       rx_act;
    logic       col_act;
  } lstat_t;

  // Lit/unlit decision for one LED, before polarity.
  function automatic logic evt_lit(input logic [4:0] code, input lstat_t s,
                                   input logic ph);
    logic low_grp, high_grp, any_act, res;
    low_grp  = s.link && (s.spd == 3'd1 || s.spd == 3'd2);
    high_grp = s.link && (s.spd == 3'd3 || s.spd == 3'd4 || s.spd == 3'd5);
    any_act  = s.tx_act | s.rx_act;
    case (code)
      EV_10M, EV_100M, EV_1G, EV_2G5, EV_5G, EV_10G:
                    res = s.link && (s.spd == code[2:0]);
      EV_LOWGRP:    res = low_grp;
      EV_HIGHGRP:   res = high_grp;
      EV_FDX:       res = s.link && s.fdx;
      EV_COL:       res = s.col;
      EV_TX_BLINK:  res = s.tx_act && ph;
      EV_RX_BLINK:  res = s.rx_act && ph;
      EV_ACT_BLINK: res = any_act && ph;
      EV_LINK:      res = s.link;
      EV_LINK_ACT:  res = s.link && (any_act ? ph : 1'b1);
      EV_LINK_RX:   res = s.link && (s.rx_act ? ph : 1'b1);
      EV_LOW_ACT:   res = low_grp && (any_act ? ph : 1'b1);
      EV_HIGH_ACT:  res = high_grp && (any_act ? ph : 1'b1);
      EV_HIGH_LOWB: res = high_grp || (low_grp && ph);
      EV_FDX_COLB:  res = s.link && s.fdx && (s.col_act ? ph : 1'b1);
      EV_FORCE_ON:  res = 1'b1;
      default:      res = 1'b0;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
  import led_evt_pkg::*;
#(
  parameter int          N_LED      = 5,
  parameter int          ADDR_W     = 8,
  parameter int          DATA_W     = 16,
  parameter int          RATE_W     = 8,
  parameter int          POL_ADDR   = 'h00,
  parameter int          BLINK_ADDR = 'h08,
  parameter int          LED_BASE   = 'h40,
  parameter int          LED_STRIDE = 'h10,
  parameter int          EVT_LSB    = 11,
  parameter int          POL_LSB    = 8,
  parameter logic [7:0]  RATE_RST   = 8'h0F
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [DATA_W-1:0]             rdata,
  output logic [N_LED-1:0][EVT_W-1:0]   evt_q,
  output logic [N_LED-1:0]              pol_q,
  output logic [RATE_W-1:0]             rate_q
);

  logic [N_LED-1:0][EVT_W-1:0] evt_d;
  logic [N_LED-1:0]            pol_d;
  logic [RATE_W-1:0]           rate_d;
  logic [DATA_W-1:0]           rdata_d;
  logic                        pol_hit, rate_hit;
  logic [N_LED-1:0]            led_hit;

  always_comb begin
    pol_hit  = (addr == ADDR_W'(POL_ADDR));
    rate_hit = (addr == ADDR_W'(BLINK_ADDR));
    for (int i = 0; i < N_LED; i++)
      led_hit[i] = (addr == ADDR_W'(LED_BASE + i * LED_STRIDE));
  end

  // Next state: configuration fields
  always_comb begin
    evt_d  = evt_q;
    pol_d  = pol_q;
    rate_d = rate_q;
    if (wr_en) begin
      for (int i = 0; i < N_LED; i++)
        if (led_hit[i]) evt_d[i] = wdata[EVT_LSB +: EVT_W];
      if (pol_hit)  pol_d  = wdata[POL_LSB +: N_LED];
      if (rate_hit) rate_d = wdata[RATE_W-1:0];
    end
  end

  // Next state: read mux, fields returned in place
  always_comb begin
    rdata_d = '0;
    if (rd_en) begin
      for (int i = 0; i < N_LED; i++)
        if (led_hit[i]) rdata_d[EVT_LSB +: EVT_W] = evt_q[i];
      if (pol_hit)  rdata_d[POL_LSB +: N_LED] = pol_q;
      if (rate_hit) rdata_d[RATE_W-1:0]       = rate_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N_LED; i++) evt_q[i] <= EV_FORCE_OFF;
      pol_q  <= '0;
      rate_q <= RATE_RST;
      rdata  <= '0;
    end else begin
      evt_q  <= evt_d;
      pol_q  <= pol_d;
      rate_q <= rate_d;
      rdata  <= rdata_d;
    end
  end

  AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !pol_hit && !rate_hit && led_hit == '0)
      |=> ($stable(pol_q) && $stable(rate_q) && $stable(evt_q))); // R2

  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> (rdata == '0)); // R2

endmodule

// File: rtl/led_blink_timer.sv
module led_blink_timer #(
  parameter int RATE_W   = 8,
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              tx_pulse,
  input  logic              rx_pulse,
  input  logic              collision,
  output logic              phase,
  output logic              tx_act,
  output logic              rx_act,
  output logic              col_act
);

  localparam int PS_W  = $clog2(PRESCALE + 1);
  localparam int CNT_W = RATE_W + PS_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, lim;
  logic             tick, phase_d;
  logic [2:0]       pend_q, pend_d, act_q, act_d, strobe;

  assign lim    = CNT_W'((int'(rate) + 1) * PRESCALE);
  assign tick   = (cnt_q >= lim - CNT_W'(1));
  assign strobe = {collision, rx_pulse, tx_pulse};

  // Next state: period counter, phase and activity windows
  always_comb begin
    cnt_d   = tick ? '0 : cnt_q + CNT_W'(1);
    phase_d = tick ? ~phase : phase;
    if (tick) begin
      act_d  = pend_q | strobe;
      pend_d = '0;
    end else begin
      act_d  = act_q;
      pend_d = pend_q | strobe;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      phase  <= 1'b0;
      pend_q <= '0;
      act_q  <= '0;
    end else begin
      cnt_q  <= cnt_d;
      phase  <= phase_d;
      pend_q <= pend_d;
      act_q  <= act_d;
    end
  end

  assign tx_act  = act_q[0];
  assign rx_act  = act_q[1];
  assign col_act = act_q[2];

  AST_PHASE_AT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(phase)); // R6

  AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !pend_q[0] && !tx_pulse && !pend_q[1] && !rx_pulse)
      |=> (!tx_act && !rx_act)); // R6

endmodule

// File: rtl/led_lane.sv
module led_lane
  import led_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EVT_W-1:0] code,
  input  logic             pol,
  input  lstat_t           st,
  input  logic             phase,
  output logic             led_q
);

  logic lit, led_d;

  always_comb begin
    lit   = evt_lit(code, st, phase);
    led_d = lit ^ pol;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) led_q <= 1'b0;
    else        led_q <= led_d;
  end

  AST_FORCE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (code == EV_FORCE_ON) |=> (led_q == !$past(pol))); // R9

  AST_UNDEF_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (code > EV_FORCE_OFF) |=> (led_q == $past(pol))); // R9

  AST_POL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (code == EV_FORCE_OFF) |=> (led_q == $past(pol))); // R10

endmodule

// File: rtl/led_event_ctrl.sv
module led_event_ctrl
  import led_evt_pkg::*;
#(
  parameter int N_LED    = 5,
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 16,
  parameter int RATE_W   = 8,
  parameter int PRESCALE = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              link_up,
  input  logic [2:0]        speed,
  input  logic              full_dup,
  input  logic              collision,
  input  logic              tx_pulse,
  input  logic              rx_pulse,
  output logic [N_LED-1:0]  led_o
);

  logic [1:0]                  rst_sync;
  logic                        rst_int_n;
  logic [N_LED-1:0][EVT_W-1:0] evt_q;
  logic [N_LED-1:0]            pol_q;
  logic [RATE_W-1:0]           rate_q;
  logic                        phase, tx_act, rx_act, col_act;
  lstat_t                      st;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  led_cfg_regs #(
    .N_LED(N_LED), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RATE_W(RATE_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .evt_q(evt_q), .pol_q(pol_q), .rate_q(rate_q)
  );

  led_blink_timer #(.RATE_W(RATE_W), .PRESCALE(PRESCALE)) u_timer (
    .clk(clk), .rst_n(rst_int_n), .rate(rate_q),
    .tx_pulse(tx_pulse), .rx_pulse(rx_pulse), .collision(collision),
    .phase(phase), .tx_act(tx_act), .rx_act(rx_act), .col_act(col_act)
  );

  always_comb begin
    st.link    = link_up;
    st.spd     = speed;
    st.fdx     = full_dup;
    st.col     = collision;
    st.tx_act  = tx_act;
    st.rx_act  = rx_act;
    st.col_act = col_act;
  end

  for (genvar g = 0; g < N_LED; g++) begin : g_lane
    led_lane u_lane (
      .clk(clk), .rst_n(rst_int_n), .code(evt_q[g]), .pol(pol_q[g]),
      .st(st), .phase(phase), .led_q(led_o[g])
    );
  end

  AST_RESET_DARK: assert property (@(posedge clk)
    !rst_int_n |=> (led_o == '0)); // R1

endmodule

// File: tb/sim_led_event_ctrl.sv
`timescale 1ns/1ps
module sim_led_event_ctrl;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [7:0]  addr;
  logic [15:0] wdata;
  logic [15:0] rdata;
  logic        link_up, full_dup, collision, tx_pulse, rx_pulse;
  logic [2:0]  speed;
  logic [4:0]  led_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  typedef struct {
    bit          is_rd;
    logic [15:0] exp;
    logic [15:0] mask;
    int          req;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  led_event_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .link_up(link_up), .speed(speed),
    .full_dup(full_dup), .collision(collision), .tx_pulse(tx_pulse),
    .rx_pulse(rx_pulse), .led_o(led_o)
  );

  task automatic check(input int req, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Monitor: pops one expectation per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        if (it.is_rd) check(it.req, rdata & it.mask, it.exp & it.mask);
        else          check(it.req, {11'b0, led_o} & it.mask, it.exp & it.mask);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0; addr = 8'hFF; wdata = 16'h0;
  endtask

  task automatic set_code(input int led, input logic [4:0] c);
    wr(8'(8'h40 + led * 16), {c, 11'h0});
  endtask

  task automatic exp_led(input int led, input logic e, input int req);
    item_t it;
    @(posedge clk); @(posedge clk); #1;
    it.is_rd = 0; it.exp = 16'(e) << led; it.mask = 16'h1 << led; it.req = req;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [15:0] e, input int req);
    item_t it;
    @(negedge clk); rd_en = 1; addr = a;
    @(posedge clk); #1;
    it.is_rd = 1; it.exp = e; it.mask = 16'hFFFF; it.req = req;
    sb.push_back(it);
    @(negedge clk); rd_en = 0; addr = 8'hFF;
    #1;
  endtask

  // Counts toggles of one LED; gaps after the first toggle must equal period
  task automatic watch(input int led, input int cycles, input int period,
                       input bit tx_on, input bit rx_on,
                       output int tog, output int bad_gap);
    logic prev;
    int   last;
    tog = 0; bad_gap = 0; last = -1;
    @(negedge clk); prev = led_o[led];
    fork
      begin
        for (int c = 0; c < cycles; c++) begin
          @(negedge clk);
          if (led_o[led] !== prev) begin
            if (last >= 0 && (c - last) != period) bad_gap++;
            last = c; tog++;
            prev = led_o[led];
          end
        end
      end
      begin
        for (int c = 0; c < cycles / 4; c++) begin
          @(negedge clk); tx_pulse = tx_on; rx_pulse = rx_on;
          @(negedge clk); tx_pulse = 0; rx_pulse = 0;
          @(negedge clk); @(negedge clk);
        end
      end
    join
    tx_pulse = 0; rx_pulse = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int tog, gap;
    rst_n = 0; wr_en = 0; rd_en = 0; addr = 8'hFF; wdata = 0;
    link_up = 0; speed = 0; full_dup = 0; collision = 0; tx_pulse = 0; rx_pulse = 0;
    repeat (4) @(negedge clk);
    check(1, {11'b0, led_o}, 16'h0);      // R1 dark in reset
    check(1, rdata, 16'h0);               // R1
    rst_n = 1;
    repeat (5) @(negedge clk);
    check(1, {11'b0, led_o}, 16'h0);      // R1 after release
    rd_chk(8'h40, 16'hA800, 1);           // R1 code 0x15 after reset
    rd_chk(8'h08, 16'h000F, 1);           // R1 rate reset value
    rd_chk(8'h00, 16'h0000, 1);           // R1 polarity clear

    // R2 field placement and read-back
    wr(8'h70, 16'hFFFF);
    rd_chk(8'h70, 16'hF800, 2);           // R2 LED3 event bits 15:11
    wr(8'h00, 16'hFFFF);
    rd_chk(8'h00, 16'h1F00, 2);           // R2 polarity bits 12:8
    wr(8'h00, 16'h0000);
    wr(8'h08, 16'hFF01);
    rd_chk(8'h08, 16'h0001, 2);           // R2 rate bits 7:0 (period 8)
    set_code(3, 5'h15);
    set_code(4, 5'h14);
    exp_led(4, 1, 2);                     // R2 stride reaches LED4
    wr(8'h44, 16'hA000);                  // unmapped
    rd_chk(8'h40, 16'hA800, 2);           // R2 unmapped write ignored
    exp_led(0, 0, 2);                     // R2
    set_code(4, 5'h15);

    // R3 single speeds
    link_up = 1;
    for (int c = 0; c < 6; c++) begin
      set_code(0, 5'(c));
      for (int s = 0; s < 6; s++) begin
        speed = 3'(s);
        exp_led(0, c == s, 3);            // R3
      end
    end
    speed = 3'd2; link_up = 0;
    set_code(0, 5'h02);
    exp_led(0, 0, 3);                     // R3 link down stays dark
    link_up = 1;
    @(negedge clk); link_up = 0;
    @(posedge clk); #1;                   // one edge after change
    begin item_t it; it.is_rd = 0; it.exp = 0; it.mask = 1; it.req = 3; sb.push_back(it); end
    @(negedge clk); #1;

    // R4 groups
    link_up = 1;
    set_code(0, 5'h06);
    speed = 3'd1; exp_led(0, 1, 4);
    speed = 3'd2; exp_led(0, 1, 4);
    speed = 3'd4; exp_led(0, 0, 4);
    set_code(0, 5'h07);
    speed = 3'd3; exp_led(0, 1, 4);
    speed = 3'd5; exp_led(0, 1, 4);
    speed = 3'd0; exp_led(0, 0, 4);

    // R5 duplex, collision, link
    set_code(0, 5'h08);
    full_dup = 1; exp_led(0, 1, 5);
    full_dup = 0; exp_led(0, 0, 5);
    set_code(0, 5'h09);
    collision = 1; exp_led(0, 1, 5);
    collision = 0; exp_led(0, 0, 5);
    set_code(0, 5'h0D);
    exp_led(0, 1, 5);
    link_up = 0; exp_led(0, 0, 5);
    link_up = 1;
    repeat (30) @(negedge clk);           // let collision activity expire

    // R6 activity blink at exact period
    set_code(0, 5'h0C);
    watch(0, 96, 8, 1, 0, tog, gap);
    check(6, 16'(tog >= 6), 16'h1);       // R6 toggles while active
    check(6, 16'(gap), 16'h0);            // R6 gap equals period
    repeat (24) @(negedge clk);
    watch(0, 32, 8, 0, 0, tog, gap);
    check(6, 16'(tog), 16'h0);            // R6 steady after idle
    exp_led(0, 0, 6);
    set_code(0, 5'h0B);
    watch(0, 64, 8, 1, 0, tog, gap);
    check(6, 16'(tog), 16'h0);            // R6 rx code ignores tx
    set_code(0, 5'h0A);
    watch(0, 64, 8, 1, 0, tog, gap);
    check(6, 16'(tog >= 4), 16'h1);       // R6 tx code blinks
    repeat (24) @(negedge clk);

    // R7 combined steady/blink
    set_code(0, 5'h0E); speed = 3'd5;
    exp_led(0, 1, 7);                     // R7 link steady
    watch(0, 64, 8, 0, 1, tog, gap);
    check(7, 16'(tog >= 4), 16'h1);       // R7 link+activity blinks
    repeat (24) @(negedge clk);
    set_code(0, 5'h0F);
    watch(0, 64, 8, 1, 0, tog, gap);
    check(7, 16'(tog), 16'h0);            // R7 rx-only blink ignores tx
    repeat (24) @(negedge clk);
    exp_led(0, 1, 7);
    set_code(0, 5'h10); speed = 3'd2;
    exp_led(0, 1, 7);                     // R7 low group steady
    speed = 3'd4; exp_led(0, 0, 7);
    set_code(0, 5'h11);
    exp_led(0, 1, 7);                     // R7 high group steady
    set_code(0, 5'h13); full_dup = 1;
    exp_led(0, 1, 7);                     // R7 fdx steady
    full_dup = 0; exp_led(0, 0, 7);

    // R8 high steady, low blinks with no activity
    set_code(0, 5'h12);
    speed = 3'd4; exp_led(0, 1, 8);
    watch(0, 48, 8, 0, 0, tog, gap);
    check(8, 16'(tog), 16'h0);            // R8 steady high
    speed = 3'd1;
    watch(0, 48, 8, 0, 0, tog, gap);
    check(8, 16'(tog >= 4), 16'h1);       // R8 low blinks
    check(8, 16'(gap), 16'h0);

    // R9 forced and undefined
    set_code(0, 5'h14); exp_led(0, 1, 9);
    set_code(0, 5'h15); exp_led(0, 0, 9);
    set_code(0, 5'h16); exp_led(0, 0, 9);
    set_code(0, 5'h1F); exp_led(0, 0, 9);

    // R10 polarity
    wr(8'h00, 16'h0100);
    exp_led(0, 1, 10);                    // R10 off code reads high
    set_code(0, 5'h14); exp_led(0, 0, 10);
    set_code(2, 5'h14); exp_led(2, 1, 10); // other LED unaffected
    wr(8'h00, 16'h0400);
    exp_led(2, 0, 10);

    repeat (4) @(negedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule